// File: doc/BRIEF.md
# Prescaled 16-bit Event Timer

This block is a 16-bit up-counter placed behind an 8-bit register port. It advances either on an internal quarter-rate tick (one tick every four system clocks) or on rising edges of an external clock pin. The selected source passes through a power-of-two prescaler before it reaches the counter.

External edges can take one of two paths. The full path goes through a two-stage synchronizer. The short path reacts one clock sooner. A clear strobe from a neighbouring capture/compare unit forces the count to zero. When the count wraps from all ones to zero, a sticky interrupt flag is set.

With wide access enabled, a shadow register for the upper byte lets software read or load all 16 bits coherently over the 8-bit bus. Software configures the block and reads the count through three byte addresses: count low at address 0, count high at address 1, and control at address 2. The capture/compare unit drives the clear strobe directly.

Top module: `evt_timer16`

## Requirements
- R1: With control bit 1 = 0 (internal source), control bit 0 = 1 (run) and prescale code 0, the count advances by one every 4 system clocks. The first step lands on the 4th clock edge after the edge that wrote a count byte.
- R2: The prescale code in control bits 4:3 selects a division of 1, 2, 4 or 8 for codes 0, 1, 2 and 3. With division N on the internal source, the count after k edges from a count write is floor(k / (4*N)).
- R3: With control bit 1 = 1, the count advances once per rising edge of ext_clk_i (after prescaling). A level held high gives exactly one step.
- R4: Control bit 2 selects the edge path. With 0 (synchronized), the step shows 2 clock edges after the first edge that samples ext_clk_i high. With 1 (short path), it shows 1 edge after.
- R5: With control bit 0 = 0, the count holds its value whatever the source does.
- R6: A step from 0xFFFF wraps the count to 0x0000 and sets the flag (control bit 7). irq_o follows the flag.
- R7: The flag stays set until software writes control with bit 7 = 0. Writing bit 7 = 1 neither sets nor clears it.
- R8: A high cycle on trig_clr_i makes the count 0x0000 at the next edge. This clear wins over a step and a bus write in that same cycle, and a wrap in that same cycle still sets the flag.
- R9: With control bit 5 = 1 (wide access), a read strobe at address 0 copies the live upper byte into the shadow, and reads at address 1 return the shadow.
- R10: With wide access, a write to address 1 goes only to the shadow and leaves the count unchanged. A write to address 0 loads {shadow, data} into the count in one step.
- R11: With control bit 5 = 0, address 1 reads and writes the live upper byte directly, and a write to address 0 changes only the lower byte.
- R12: A write to either count byte restarts both the prescaler and the quarter-rate divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_clk_i | input | 1 | External count input, asynchronous to clk |
| trig_clr_i | input | 1 | Clear strobe from the capture/compare unit |
| bus_addr_i | input | 2 | Register select: 0 count low, 1 count high, 2 control |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (drives the shadow capture) |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Read data, combinational from the address |
| irq_o | output | 1 | Sticky overflow flag |

## Verification
A divider or prescaler out of phase shows up as a count that is off by one step on the first sample after a count write, which is at most 32 clocks later. A synchronizer stage too many or too few moves the external step by a cycle, and the fixed-latency reads see that on the edge where it happens. A shadow register that is loaded at the wrong time returns the live upper byte in place of the captured one as soon as the count carries into bit 8. A flag or clear fault shows on irq_o or on the count in the cycle right after the wrap or the strobe.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;

  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // control byte layout, MSB first
  typedef struct packed {
    logic       flag;      // bit 7 sticky wrap flag
    logic       spare;     // bit 6 reads zero
    logic       wide;      // bit 5 coherent 16-bit access
    logic [1:0] psc;       // bits 4:3 prescale code
    logic       fast_ext;  // bit 2 short external edge path
    logic       src_ext;   // bit 1 external source
    logic       run;       // bit 0 counting enable
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/evt_timer16_qtick.sv
// Quarter-rate tick: one pulse every 2**DIV_W clocks, restartable.
module evt_timer16_qtick #(
  parameter int unsigned DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);

  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    div_d = restart_i ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = (div_q == {DIV_W{1'b1}}) && !restart_i;

endmodule

// File: rtl/evt_timer16_extedge.sv
// Synchronizer chain with two rising-edge taps: after stage 0 or after the last stage.
module evt_timer16_extedge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  input  logic fast_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              edge_fast, edge_full;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= ext_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign edge_fast = sync_q[0] && !sync_q[1];
  assign edge_full = sync_q[STAGES-1] && !last_q;
  assign edge_o    = fast_i ? edge_fast : edge_full;

endmodule

// File: rtl/evt_timer16_prescale.sv
// Power-of-two prescaler: passes one source tick out of 2**sel_i.
module evt_timer16_prescale #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             src_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);

  localparam int unsigned PCNT_W = (1 << SEL_W) - 1;

  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [PCNT_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PCNT_W; i++) begin
      if (i < int'(sel_i)) mask[i] = 1'b1;
    end
  end

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart_i)       pcnt_d = '0;
    else if (src_tick_i) pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign step_o = src_tick_i && !restart_i && ((pcnt_q & mask) == mask);

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16 #(
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned DIV_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic             trig_clr_i,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             irq_o
);
  import evt_timer16_pkg::*;

  localparam int unsigned CNT_W = 2 * BUS_W;
  localparam int unsigned PSC_W = 2;

  // reset: asserted at once, released after two clocks
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  reg_sel_e   sel;
  logic       wr_lo, wr_hi, wr_ctl, rd_lo;
  ctrl_t      ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BUS_W-1:0] shadow_q, shadow_d;
  logic       restart, int_tick, ext_edge, src_tick, step, wrap_evt, run_w;

  assign sel    = reg_sel_e'(bus_addr_i);
  assign wr_lo  = bus_wr_i && (sel == SEL_CNT_LO);
  assign wr_hi  = bus_wr_i && (sel == SEL_CNT_HI);
  assign wr_ctl = bus_wr_i && (sel == SEL_CTRL);
  assign rd_lo  = bus_rd_i && (sel == SEL_CNT_LO);
  assign restart = wr_lo || wr_hi;
  assign run_w   = ctrl_q.run;

  evt_timer16_qtick #(.DIV_W(DIV_W)) u_qtick (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .restart_i (restart),
    .tick_o    (int_tick)
  );

  evt_timer16_extedge #(.STAGES(SYNC_STAGES)) u_extedge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ext_i  (ext_clk_i),
    .fast_i (ctrl_q.fast_ext),
    .edge_o (ext_edge)
  );

  assign src_tick = ctrl_q.run && (ctrl_q.src_ext ? ext_edge : int_tick);

  evt_timer16_prescale #(.SEL_W(PSC_W)) u_psc (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .restart_i  (restart),
    .src_tick_i (src_tick),
    .sel_i      (ctrl_q.psc),
    .step_o     (step)
  );

  // a step that carries out of the top bit; bus loads suppress it
  assign wrap_evt = step && (cnt_q == {CNT_W{1'b1}}) && !wr_lo && !(wr_hi && !ctrl_q.wide);

  // count next state: clear > byte load > step
  always_comb begin
    cnt_d = cnt_q;
    if (trig_clr_i) begin
      cnt_d = '0;
    end else if (wr_lo) begin
      cnt_d[BUS_W-1:0] = bus_wdata_i;
      if (ctrl_q.wide) cnt_d[CNT_W-1:BUS_W] = shadow_q;
    end else if (wr_hi && !ctrl_q.wide) begin
      cnt_d[CNT_W-1:BUS_W] = bus_wdata_i;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // shadow of the upper byte
  always_comb begin
    shadow_d = shadow_q;
    if (ctrl_q.wide && wr_hi)      shadow_d = bus_wdata_i;
    else if (ctrl_q.wide && rd_lo) shadow_d = cnt_q[CNT_W-1:BUS_W];
  end

  // control and sticky flag
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctl) begin
      ctrl_d       = ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
      ctrl_d.spare = 1'b0;
      ctrl_d.flag  = ctrl_q.flag && bus_wdata_i[CTRL_W-1];
    end
    if (wrap_evt) ctrl_d.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      ctrl_q   <= '0;
    end else begin
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
      ctrl_q   <= ctrl_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (sel)
      SEL_CNT_LO: bus_rdata_o = cnt_q[BUS_W-1:0];
      SEL_CNT_HI: bus_rdata_o = ctrl_q.wide ? shadow_q : cnt_q[CNT_W-1:BUS_W];
      SEL_CTRL:   bus_rdata_o = BUS_W'(ctrl_q);
      default:    bus_rdata_o = '0;
    endcase
  end

  assign irq_o = ctrl_q.flag;

endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic             wr_i,
  input logic [1:0]       addr_i,
  input logic             wd7_i,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             irq_i
);

  a_r8_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (cnt_i == '0));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !(wr_i && addr_i == 2'd2 && !wd7_i)) |=> irq_i);

  a_r7_flag_only_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_i && cnt_i != {CNT_W{1'b1}}) |=> !irq_i);

  a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !trig_i && !wr_i) |=> $stable(cnt_i));

  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !wr_i) |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + CNT_W'(1)));

  a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !wr_i && cnt_i == {CNT_W{1'b1}}) |=> (cnt_i == {CNT_W{1'b1}} || irq_i));

endmodule

bind evt_timer16 evt_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_s),
  .trig_i (trig_clr_i),
  .wr_i   (bus_wr_i),
  .addr_i (bus_addr_i),
  .wd7_i  (bus_wdata_i[7]),
  .run_i  (run_w),
  .cnt_i  (cnt_q),
  .irq_i  (irq_o)
);

// File: tb/evt_timer16_bench.sv
`timescale 1ns/1ps
module evt_timer16_bench;

  logic       clk;
  logic       rst_n;
  logic       ext_clk;
  logic       trig;
  logic [1:0] addr;
  logic       wr, rd;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  evt_timer16 u_evt_timer16 (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_clk_i   (ext_clk),
    .trig_clr_i  (trig),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {prescale code, edges after the count write, expected count}
  localparam logic [33:0] VECS [8] = '{
    {2'd0, 16'd3,  16'd0},
    {2'd0, 16'd4,  16'd1},
    {2'd0, 16'd41, 16'd10},
    {2'd1, 16'd7,  16'd0},
    {2'd1, 16'd8,  16'd1},
    {2'd2, 16'd33, 16'd2},
    {2'd3, 16'd31, 16'd0},
    {2'd3, 16'd64, 16'd2}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // both tasks start and end at a falling edge
  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1;
    repeat (2) @(negedge clk);
    ext_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; ext_clk = 1'b0; trig = 1'b0;
    addr = 2'd0; wr = 1'b0; rd = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("reset irq", {7'b0, irq}, 8'h00);
    brd(2'd2, v); check("reset ctrl", v, 8'h00);
    brd(2'd0, v); check("reset count", v, 8'h00);

    // R1 R2 R12: internal source, each prescale, timed from a count write
    for (int i = 0; i < 8; i++) begin
      logic [1:0]  ps;
      logic [15:0] k, e;
      {ps, k, e} = VECS[i];
      bwr(2'd2, 8'h21 | (8'(ps) << 3));
      bwr(2'd1, 8'h00);
      bwr(2'd0, 8'h00);
      repeat (int'(k)) @(posedge clk);
      @(negedge clk);
      brd(2'd0, v);
      check($sformatf("R1/R2/R12 vec %0d", i), v, e[7:0]);
    end

    // R4 synchronized path, R3 level held high counts once
    bwr(2'd2, 8'h23);
    bwr(2'd1, 8'h00);
    bwr(2'd0, 8'h00);
    ext_clk = 1'b1;
    @(posedge clk);
    @(negedge clk);
    brd(2'd0, v); check("R4 sync edge+0", v, 8'h00);
    brd(2'd0, v); check("R4 sync edge+1", v, 8'h00);
    brd(2'd0, v); check("R4 sync edge+2", v, 8'h01);
    repeat (5) brd(2'd0, v);
    check("R3 held level single step", v, 8'h01);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);

    // R4 short path
    bwr(2'd2, 8'h27);
    ext_clk = 1'b1;
    @(posedge clk);
    @(negedge clk);
    brd(2'd0, v); check("R4 fast edge+0", v, 8'h01);
    brd(2'd0, v); check("R4 fast edge+1", v, 8'h02);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);

    // R3 R2: external edges through divide-by-4
    bwr(2'd2, 8'h33);
    bwr(2'd1, 8'h00);
    bwr(2'd0, 8'h00);
    repeat (3) ext_pulse();
    repeat (3) @(negedge clk);
    brd(2'd0, v); check("R3 three edges div4", v, 8'h00);
    ext_pulse();
    repeat (3) @(negedge clk);
    brd(2'd0, v); check("R3 four edges div4", v, 8'h01);

    // R5 hold when stopped
    bwr(2'd2, 8'h20);
    bwr(2'd1, 8'h0A);
    bwr(2'd0, 8'hBC);
    repeat (20) @(negedge clk);
    brd(2'd0, v); check("R5 hold low", v, 8'hBC);
    brd(2'd1, v); check("R5 hold high", v, 8'h0A);

    // R6 wrap
    bwr(2'd2, 8'h21);
    bwr(2'd1, 8'hFF);
    bwr(2'd0, 8'hFF);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 no flag before wrap", {7'b0, irq}, 8'h00);
    brd(2'd0, v); check("R6 at FFFF", v, 8'hFF);
    check("R6 flag after wrap", {7'b0, irq}, 8'h01);
    brd(2'd0, v); check("R6 wrapped to zero", v, 8'h00);

    // R7 flag write rules
    bwr(2'd2, 8'hA1);
    check("R7 write one keeps flag", {7'b0, irq}, 8'h01);
    bwr(2'd2, 8'h21);
    check("R7 write zero clears", {7'b0, irq}, 8'h00);
    bwr(2'd2, 8'hA0);
    check("R7 write one does not set", {7'b0, irq}, 8'h00);

    // R8 clear on the wrap cycle
    bwr(2'd2, 8'h21);
    bwr(2'd1, 8'hFF);
    bwr(2'd0, 8'hFF);
    repeat (3) @(posedge clk);
    @(negedge clk);
    trig = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trig = 1'b0;
    check("R8 flag set despite clear", {7'b0, irq}, 8'h01);
    brd(2'd0, v); check("R8 low zero", v, 8'h00);
    brd(2'd1, v); check("R8 high zero", v, 8'h00);

    // R8 plain clear
    bwr(2'd2, 8'h20);
    bwr(2'd1, 8'h12);
    bwr(2'd0, 8'h34);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    brd(2'd0, v); check("R8 plain low", v, 8'h00);
    brd(2'd1, v); check("R8 plain high", v, 8'h00);

    // R9 coherent read across a carry into the upper byte
    bwr(2'd2, 8'h21);
    bwr(2'd1, 8'h00);
    bwr(2'd0, 8'hFE);
    repeat (4) @(posedge clk);
    @(negedge clk);
    brd(2'd0, v); check("R9 low at 00FF", v, 8'hFF);
    repeat (6) @(posedge clk);
    @(negedge clk);
    brd(2'd1, v); check("R9 high from shadow", v, 8'h00);
    brd(2'd0, v); check("R9 low at 0101", v, 8'h01);
    brd(2'd1, v); check("R9 high refreshed", v, 8'h01);

    // R10 buffered high write
    bwr(2'd2, 8'h20);
    bwr(2'd1, 8'h11);
    bwr(2'd0, 8'h11);
    bwr(2'd1, 8'h56);
    brd(2'd0, v);
    brd(2'd1, v); check("R10 high write alone ignored", v, 8'h11);
    bwr(2'd1, 8'h77);
    bwr(2'd0, 8'h88);
    brd(2'd0, v); check("R10 low of pair", v, 8'h88);
    brd(2'd1, v); check("R10 high of pair", v, 8'h77);

    // R11 byte mode
    bwr(2'd2, 8'h00);
    bwr(2'd1, 8'h9A);
    brd(2'd1, v); check("R11 direct high", v, 8'h9A);
    bwr(2'd0, 8'h33);
    brd(2'd0, v); check("R11 low write", v, 8'h33);
    brd(2'd1, v); check("R11 high untouched", v, 8'h9A);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule